// File: doc/BRIEF.md
# Exception Return Control Unit

This block retires the privileged return-from-exception operation of a processor core. Each cycle it looks at one 32-bit instruction word and a valid strobe. When the word is the return operation and the core is allowed to run it, the block picks one of two saved return addresses. It clears the matching level bit, may restore the current shadow register set from the previous one, and splits the address into a fetch PC and an instruction-set mode bit. It then signals a flush of younger instructions together with a hazard barrier. The operation has no delay slot, so the instruction after it is never executed.

Every result is registered. The results appear in the cycle after the cycle in which the strobe and the matching word were sampled. The pulse outputs stay high for exactly that one cycle. The address, mode, level and shadow-set outputs hold their last committed values until the next commit.

A small state machine runs the block:

- **S_IDLE**: no operation completes.
- **S_RETIRE**: a return is committed.
- **S_FAULT**: a return was attempted from user mode without coprocessor-0 access.

The machine computes its next state on every clock:

- **IDLE→RETIRE / RETIRE→RETIRE / FAULT→RETIRE**: a valid, permitted return.
- **any→FAULT**: a valid return that is not permitted.
- **any→IDLE**: every other input.

Top module: `xret_ctrl`

## Requirements
- R1: The operation is recognised only when `instr_vld_i` is 1 and `instr_i` equals 32'h0000_F37C. Any other word, or a low strobe, produces no pulse, and all held outputs keep their values.
- R2: When `err_lvl_i` is 1, the return address is `err_ret_addr_i` and `err_lvl_o` becomes 0. `exc_lvl_o` takes the value of `exc_lvl_i`. The error level has priority over the exception level.
- R3: When `err_lvl_i` is 0, the return address is `exc_ret_addr_i` and both `exc_lvl_o` and `err_lvl_o` become 0.
- R4: On the exception-address path, `shadow_cur_o` takes `shadow_prev_i` only if three conditions all hold: `arch_rev_i` >= 2, `shadow_top_i` != 0, and `boot_vec_i` is 0. Otherwise it takes `shadow_cur_i`.
- R5: On the error-address path, `shadow_cur_o` always takes `shadow_cur_i`, whatever the values of `shadow_top_i` and `boot_vec_i`.
- R6: Dual-ISA mode is on when `cisa_present_i` is 1 or `isa_cfg_i` is nonzero. In that mode `redirect_pc_o` is the return address with bit 0 forced to 0, and `isa_mode_o` is bit 0 of the return address. Otherwise `redirect_pc_o` is the full address and `isa_mode_o` is 0.
- R7: `ll_clear_o` pulses with every committed return.
- R8: `commit_o`, `flush_o` and `barrier_o` are high together for exactly one cycle. That cycle is the one after the strobe and matching word are sampled.
- R9: The core is in user mode when `user_mode_i` is 1 and both level inputs are 0. A return in user mode with `cop0_en_i` 0 pulses `cop_unusable_o` instead. In that case there is no commit, no flush and no change to any held output.
- R10: A synchronous active-high `rst` clears all pulse outputs and all held outputs to 0.
- R11: Returns on consecutive cycles each commit, in consecutive cycles, with their own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| instr_vld_i | input | 1 | Instruction valid strobe |
| exc_ret_addr_i | input | 32 | Saved exception return address |
| err_ret_addr_i | input | 32 | Saved error return address |
| err_lvl_i | input | 1 | Error level status bit |
| exc_lvl_i | input | 1 | Exception level status bit |
| boot_vec_i | input | 1 | Boot exception vector status bit |
| user_mode_i | input | 1 | User mode status bit |
| cop0_en_i | input | 1 | Coprocessor-0 access enable |
| shadow_top_i | input | 4 | Highest implemented shadow set |
| shadow_cur_i | input | 4 | Current shadow set |
| shadow_prev_i | input | 4 | Previous shadow set |
| arch_rev_i | input | 3 | Architecture revision |
| cisa_present_i | input | 1 | Compressed 16-bit ISA present |
| isa_cfg_i | input | 2 | ISA configuration field |
| commit_o | output | 1 | Return committed pulse |
| redirect_pc_o | output | 32 | Fetch redirect PC (held) |
| isa_mode_o | output | 1 | ISA mode after return (held) |
| err_lvl_o | output | 1 | New error level (held) |
| exc_lvl_o | output | 1 | New exception level (held) |
| shadow_cur_o | output | 4 | New current shadow set (held) |
| ll_clear_o | output | 1 | Load-linked flag clear pulse |
| flush_o | output | 1 | Flush of younger instructions pulse |
| barrier_o | output | 1 | Hazard barrier pulse |
| cop_unusable_o | output | 1 | Coprocessor-unusable exception pulse |

## Verification
A wrong state-machine state shows up in the very next cycle. Symptoms are a flush with no matching strobe, a flush that lasts two cycles, or a fault pulse next to a commit. A wrong held register shows up as a redirect PC, mode bit or shadow-set value that changes on a non-matching or faulted word, or that holds the wrong source after a commit. The bench compares every output one cycle after each strobe, and checks again one cycle later that the pulses have dropped.

// File: rtl/xret_pkg.sv
package xret_pkg;

    localparam int unsigned INSTR_W = 32;

    // Encoding fields of the return operation, high to low.
    localparam logic [5:0] ENC_MAJOR = 6'b000000;
    localparam logic [9:0] ENC_ZERO  = 10'b0000000000;
    localparam logic [9:0] ENC_MINOR = 10'b1111001101;
    localparam logic [5:0] ENC_POOL  = 6'b111100;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RETIRE = 2'd1,
        S_FAULT  = 2'd2
    } xret_state_e;

endpackage

// File: rtl/xret_decoder.sv
module xret_decoder
    import xret_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    output logic               hit_o
);
    logic major_ok, zero_ok, minor_ok, pool_ok;

    always_comb begin
        major_ok = (instr_i[31:26] == ENC_MAJOR);
        zero_ok  = (instr_i[25:16] == ENC_ZERO);
        minor_ok = (instr_i[15:6]  == ENC_MINOR);
        pool_ok  = (instr_i[5:0]   == ENC_POOL);
        hit_o    = valid_i && major_ok && zero_ok && minor_ok && pool_ok;
    end
endmodule

// File: rtl/xret_privcheck.sv
module xret_privcheck (
    input  logic hit_i,
    input  logic user_mode_i,
    input  logic cop0_en_i,
    input  logic err_lvl_i,
    input  logic exc_lvl_i,
    output logic permit_o,
    output logic fault_o
);
    logic in_user;
    logic allowed;

    always_comb begin
        // Either level bit forces kernel privilege.
        in_user  = user_mode_i && !err_lvl_i && !exc_lvl_i;
        allowed  = !in_user || cop0_en_i;
        permit_o = hit_i && allowed;
        fault_o  = hit_i && !allowed;
    end
endmodule

// File: rtl/xret_resolver.sv
module xret_resolver #(
    parameter int unsigned AW       = 32,
    parameter int unsigned SRS_W    = 4,
    parameter int unsigned REV_W    = 3,
    parameter int unsigned ISACFG_W = 2,
    parameter int unsigned MIN_REV  = 2
) (
    input  logic [AW-1:0]       exc_addr_i,
    input  logic [AW-1:0]       err_addr_i,
    input  logic                err_lvl_i,
    input  logic                exc_lvl_i,
    input  logic                boot_vec_i,
    input  logic [SRS_W-1:0]    top_i,
    input  logic [SRS_W-1:0]    cur_i,
    input  logic [SRS_W-1:0]    prev_i,
    input  logic [REV_W-1:0]    rev_i,
    input  logic                cisa_i,
    input  logic [ISACFG_W-1:0] isacfg_i,
    output logic [AW-1:0]       pc_o,
    output logic                isa_o,
    output logic                err_nx_o,
    output logic                exc_nx_o,
    output logic [SRS_W-1:0]    css_nx_o
);
    localparam logic [REV_W-1:0] REV_FLOOR = REV_W'(MIN_REV);

    logic [AW-1:0] ret_addr;
    logic          rev_ok, restore, dual;

    always_comb begin
        // Error level wins over exception level.
        ret_addr = err_lvl_i ? err_addr_i : exc_addr_i;
        err_nx_o = 1'b0;
        exc_nx_o = err_lvl_i ? exc_lvl_i : 1'b0;

        rev_ok   = (rev_i >= REV_FLOOR);
        restore  = !err_lvl_i && rev_ok && (top_i != '0) && !boot_vec_i;
        css_nx_o = restore ? prev_i : cur_i;

        dual = cisa_i || (isacfg_i != '0);
        if (dual) begin
            pc_o  = {ret_addr[AW-1:1], 1'b0};
            isa_o = ret_addr[0];
        end else begin
            pc_o  = ret_addr;
            isa_o = 1'b0;
        end
    end
endmodule

// File: rtl/xret_ctrl.sv
module xret_ctrl
    import xret_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned SRS_W    = 4,
    parameter int unsigned REV_W    = 3,
    parameter int unsigned ISACFG_W = 2,
    parameter int unsigned MIN_REV  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic                instr_vld_i,
    input  logic [AW-1:0]       exc_ret_addr_i,
    input  logic [AW-1:0]       err_ret_addr_i,
    input  logic                err_lvl_i,
    input  logic                exc_lvl_i,
    input  logic                boot_vec_i,
    input  logic                user_mode_i,
    input  logic                cop0_en_i,
    input  logic [SRS_W-1:0]    shadow_top_i,
    input  logic [SRS_W-1:0]    shadow_cur_i,
    input  logic [SRS_W-1:0]    shadow_prev_i,
    input  logic [REV_W-1:0]    arch_rev_i,
    input  logic                cisa_present_i,
    input  logic [ISACFG_W-1:0] isa_cfg_i,
    output logic                commit_o,
    output logic [AW-1:0]       redirect_pc_o,
    output logic                isa_mode_o,
    output logic                err_lvl_o,
    output logic                exc_lvl_o,
    output logic [SRS_W-1:0]    shadow_cur_o,
    output logic                ll_clear_o,
    output logic                flush_o,
    output logic                barrier_o,
    output logic                cop_unusable_o
);
    logic             hit, permit, fault;
    logic [AW-1:0]    nx_pc;
    logic             nx_isa, nx_err, nx_exc;
    logic [SRS_W-1:0] nx_css;
    xret_state_e      state_q, state_d;

    xret_decoder u_dec (
        .instr_i (instr_i),
        .valid_i (instr_vld_i),
        .hit_o   (hit)
    );

    xret_privcheck u_priv (
        .hit_i       (hit),
        .user_mode_i (user_mode_i),
        .cop0_en_i   (cop0_en_i),
        .err_lvl_i   (err_lvl_i),
        .exc_lvl_i   (exc_lvl_i),
        .permit_o    (permit),
        .fault_o     (fault)
    );

    xret_resolver #(
        .AW(AW), .SRS_W(SRS_W), .REV_W(REV_W),
        .ISACFG_W(ISACFG_W), .MIN_REV(MIN_REV)
    ) u_res (
        .exc_addr_i (exc_ret_addr_i),
        .err_addr_i (err_ret_addr_i),
        .err_lvl_i  (err_lvl_i),
        .exc_lvl_i  (exc_lvl_i),
        .boot_vec_i (boot_vec_i),
        .top_i      (shadow_top_i),
        .cur_i      (shadow_cur_i),
        .prev_i     (shadow_prev_i),
        .rev_i      (arch_rev_i),
        .cisa_i     (cisa_present_i),
        .isacfg_i   (isa_cfg_i),
        .pc_o       (nx_pc),
        .isa_o      (nx_isa),
        .err_nx_o   (nx_err),
        .exc_nx_o   (nx_exc),
        .css_nx_o   (nx_css)
    );

    // Next state: every state leaves on the same conditions.
    always_comb begin
        state_d = S_IDLE;
        if (permit)     state_d = S_RETIRE;
        else if (fault) state_d = S_FAULT;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Held results, loaded only when a return commits.
    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_pc_o <= '0;
            isa_mode_o    <= 1'b0;
            err_lvl_o     <= 1'b0;
            exc_lvl_o     <= 1'b0;
            shadow_cur_o  <= '0;
        end else if (state_d == S_RETIRE) begin
            redirect_pc_o <= nx_pc;
            isa_mode_o    <= nx_isa;
            err_lvl_o     <= nx_err;
            exc_lvl_o     <= nx_exc;
            shadow_cur_o  <= nx_css;
        end
    end

    // Pulse outputs decoded from the state.
    always_comb begin
        commit_o       = 1'b0;
        ll_clear_o     = 1'b0;
        flush_o        = 1'b0;
        barrier_o      = 1'b0;
        cop_unusable_o = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_RETIRE: begin
                commit_o   = 1'b1;
                ll_clear_o = 1'b1;
                flush_o    = 1'b1;
                barrier_o  = 1'b1;
            end
            S_FAULT: cop_unusable_o = 1'b1;
            default: ;
        endcase
    end

    // A flush only follows a valid matching word.
    assert_flush_after_hit_R8: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> ($past(hit) && $past(instr_vld_i)));

    // A word that did not match leaves the redirect PC where it was.
    assert_hold_on_miss_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(hit) |-> $stable(redirect_pc_o) && $stable(shadow_cur_o));

    // The error path keeps the current shadow set and clears the error level.
    assert_err_path_css_R5: assert property (@(posedge clk) disable iff (rst)
        (commit_o && $past(err_lvl_i)) |->
            (shadow_cur_o == $past(shadow_cur_i)) && !err_lvl_o);

    // The exception path returns through the exception address.
    assert_exc_path_R3: assert property (@(posedge clk) disable iff (rst)
        (commit_o && !$past(err_lvl_i)) |->
            (redirect_pc_o[AW-1:1] == $past(exc_ret_addr_i[AW-1:1])) && !exc_lvl_o);

    // A fault never commits and never changes held state.
    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        cop_unusable_o |-> !flush_o && !commit_o && $stable(redirect_pc_o));

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_o, cop_unusable_o}));

    // In dual-ISA mode the fetch PC is always even.
    assert_even_pc_R6: assert property (@(posedge clk) disable iff (rst)
        (commit_o && ($past(cisa_present_i) || ($past(isa_cfg_i) != '0)))
            |-> !redirect_pc_o[0]);

endmodule

// File: tb/xret_ctrl_bench.sv
module xret_ctrl_bench;

    typedef struct packed {
        logic [31:0] instr;
        logic        vld;
        logic [31:0] epc;
        logic [31:0] eepc;
        logic        erl;
        logic        exl;
        logic        bev;
        logic        um;
        logic        cu0;
        logic [3:0]  top;
        logic [3:0]  cur;
        logic [3:0]  prev;
        logic [2:0]  rev;
        logic        cisa;
        logic [1:0]  icfg;
    } vec_t;

    localparam logic [31:0] OPC = 32'h0000_F37C;
    localparam int NV = 11;
    // instr, vld, epc, eepc, erl, exl, bev, um, cu0, top, cur, prev, rev, cisa, icfg
    localparam vec_t VEC [NV] = '{
        '{OPC,          1'b1, 32'h8000_0181, 32'hBFC0_0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd1, 4'd5, 3'd2, 1'b0, 2'd0},
        '{OPC,          1'b1, 32'h8000_0200, 32'hBFC0_0011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd2, 4'd7, 3'd2, 1'b1, 2'd0},
        '{OPC,          1'b1, 32'h8000_0305, 32'h0,         1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd4, 4'd6, 3'd2, 1'b0, 2'd1},
        '{OPC,          1'b1, 32'h8000_0400, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 4'd9, 3'd3, 1'b0, 2'd0},
        '{OPC,          1'b1, 32'h8000_0504, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd6, 4'd1, 3'd1, 1'b0, 2'd0},
        '{32'h0000_F37D, 1'b1, 32'h1111_1110, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd8, 4'd2, 3'd2, 1'b0, 2'd0},
        '{OPC,          1'b0, 32'h2222_2220, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd8, 4'd2, 3'd2, 1'b0, 2'd0},
        '{OPC,          1'b1, 32'h3333_3330, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd8, 4'd2, 3'd2, 1'b0, 2'd0},
        '{OPC,          1'b1, 32'h4444_4441, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 4'd8, 4'd2, 3'd2, 1'b1, 2'd0},
        '{OPC,          1'b1, 32'h5555_5550, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd8, 4'd3, 3'd2, 1'b0, 2'd0},
        '{32'h0001_F37C, 1'b1, 32'h6666_6660, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd8, 4'd2, 3'd2, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    vec_t        cur_v;
    logic        commit, isa, erl_o, exl_o, llc, flush, barrier, cpu;
    logic [31:0] pc;
    logic [3:0]  css;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] e_pc;
    logic        e_isa, e_erl, e_exl, e_commit, e_fault;
    logic [3:0]  e_css;

    always #4 clk = ~clk;

    xret_ctrl u_xret_ctrl (
        .clk(clk), .rst(rst),
        .instr_i(cur_v.instr), .instr_vld_i(cur_v.vld),
        .exc_ret_addr_i(cur_v.epc), .err_ret_addr_i(cur_v.eepc),
        .err_lvl_i(cur_v.erl), .exc_lvl_i(cur_v.exl), .boot_vec_i(cur_v.bev),
        .user_mode_i(cur_v.um), .cop0_en_i(cur_v.cu0),
        .shadow_top_i(cur_v.top), .shadow_cur_i(cur_v.cur), .shadow_prev_i(cur_v.prev),
        .arch_rev_i(cur_v.rev), .cisa_present_i(cur_v.cisa), .isa_cfg_i(cur_v.icfg),
        .commit_o(commit), .redirect_pc_o(pc), .isa_mode_o(isa),
        .err_lvl_o(erl_o), .exc_lvl_o(exl_o), .shadow_cur_o(css),
        .ll_clear_o(llc), .flush_o(flush), .barrier_o(barrier), .cop_unusable_o(cpu)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input vec_t v);
        logic fire, usr, flt;
        logic [31:0] a;
        fire = v.vld && (v.instr == OPC);
        usr  = v.um && !v.erl && !v.exl;
        flt  = fire && usr && !v.cu0;
        e_commit = fire && !flt;
        e_fault  = flt;
        if (e_commit) begin
            a = v.erl ? v.eepc : v.epc;
            e_erl = 1'b0;
            e_exl = v.erl ? v.exl : 1'b0;
            e_css = (!v.erl && v.rev >= 3'd2 && v.top != 4'd0 && !v.bev) ? v.prev : v.cur;
            if (v.cisa || v.icfg != 2'd0) begin
                e_pc = {a[31:1], 1'b0}; e_isa = a[0];
            end else begin
                e_pc = a; e_isa = 1'b0;
            end
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " R8 commit"},  {31'd0, commit},  {31'd0, e_commit});
        chk({tag, " R8 flush"},   {31'd0, flush},   {31'd0, e_commit});
        chk({tag, " R8 barrier"}, {31'd0, barrier}, {31'd0, e_commit});
        chk({tag, " R7 llclear"}, {31'd0, llc},     {31'd0, e_commit});
        chk({tag, " R9 fault"},   {31'd0, cpu},     {31'd0, e_fault});
        chk({tag, " R2/R3 pc"},   pc,               e_pc);
        chk({tag, " R6 isa"},     {31'd0, isa},     {31'd0, e_isa});
        chk({tag, " R2 erl"},     {31'd0, erl_o},   {31'd0, e_erl});
        chk({tag, " R3 exl"},     {31'd0, exl_o},   {31'd0, e_exl});
        chk({tag, " R4/R5 css"},  {28'd0, css},     {28'd0, e_css});
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " R8 one-cycle flush"}, {31'd0, flush}, 32'd0);
        chk({tag, " R8 one-cycle commit"}, {31'd0, commit}, 32'd0);
        chk({tag, " R9 one-cycle fault"}, {31'd0, cpu}, 32'd0);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        vec_t idle;
        idle = VEC[0];
        idle.vld = 1'b0;
        cur_v = VEC[0];
        repeat (3) @(negedge clk);
        e_pc = '0; e_isa = 0; e_erl = 0; e_exl = 0; e_css = '0;
        e_commit = 0; e_fault = 0;
        chk_all("R10 reset");
        cur_v = idle;
        rst = 1'b0;
        @(negedge clk);
        chk_all("R10 after release");

        for (int i = 0; i < NV; i++) begin
            cur_v = VEC[i];
            model(VEC[i]);
            @(negedge clk);
            cur_v = idle;
            chk_all($sformatf("vec%0d", i));
            @(negedge clk);
            chk_quiet($sformatf("vec%0d", i));
        end

        // R11: two returns on consecutive cycles.
        cur_v = VEC[0];
        @(negedge clk);
        model(VEC[0]);
        chk_all("R11 first");
        cur_v = VEC[1];
        @(negedge clk);
        model(VEC[1]);
        cur_v = idle;
        chk_all("R11 second");
        @(negedge clk);
        chk_quiet("R11 tail");

        // R10: reset in the cycle a return is strobed clears everything.
        cur_v = VEC[2];
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur_v = idle;
        e_pc = '0; e_isa = 0; e_erl = 0; e_exl = 0; e_css = '0;
        e_commit = 0; e_fault = 0;
        chk_all("R10 mid-run reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule